// File: doc/BRIEF.md
# Code-Segment Operand Address Generator

This unit forms the operand address for loads that read constants or read-only tables out of the code segment, in either word or byte mode. A request carries the current program counter, a displacement that has already been decoded, an indirect flag, a two-bit index selector and a byte/word flag. The unit first forms a direct reference address. For an indirect request it reads the cell at that address once through a synchronous code-memory read port. The word it gets back is a signed offset relative to the cell itself. The unit then adds an index register taken from the top three slots (R5..R7) of an eight-entry register stack and returns the final address with a one-cycle done strobe.

In byte mode the sum is a byte offset. One address bit is taken up as the byte select, so only half of the segment can be reached. A direct access stays in the half that holds the program counter. An indirect access stays in the half that holds the pointer cell.

The controller has four states. ST_IDLE accepts a request (ready high). It goes to ST_FETCH when the request is indirect and to ST_CALC when it is direct. ST_FETCH issues the cell read and always moves to ST_CALC. ST_CALC combines base, index and half bit into the output registers and moves to ST_DONE. ST_DONE raises done and returns to ST_IDLE.

Top module: `cseg_addr_gen`

## Requirements
- R1: The direct reference address is req_pc + req_disp modulo 2^16. A direct word request with req_xsel = 0 returns exactly this value.
- R2: An indirect request makes exactly one memory read, at the direct reference address. The base is that address plus the returned word taken as a signed 16-bit value, modulo 2^16.
- R3: req_xsel values 1, 2 and 3 add stack register 5, 6 and 7 respectively to the base, after any indirection. Register k occupies stk_regs[16k+15:16k]. The register values are sampled when the request is accepted.
- R4: With req_xsel = 0 the base is used unchanged.
- R5: In byte mode, with sum S = base + index, out_word_addr = {half, S[15:1]}, out_byte_lo = S[0] (0 selects the high byte, at even offsets) and out_is_byte = 1. In word mode out_word_addr = S and out_byte_lo = out_is_byte = 0.
- R6: For a direct byte request, half is bit 15 of req_pc.
- R7: For an indirect byte request, half is bit 15 of the pointer-cell address.
- R8: done rises one clock edge after the accepting edge for a direct request and two edges after it for an indirect one. A direct request makes no memory read.
- R9: done lasts one cycle per request, and the outputs hold the result while done is high.
- R10: ready is high only in ST_IDLE. req_valid is ignored while ready is low and produces neither a result nor a read.
- R11: During and right after reset, ready = 1, done = 0 and mem_rd_en = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when ready is high |
| req_pc | input | 16 | Current program counter |
| req_disp | input | 16 | Decoded displacement |
| req_indirect | input | 1 | Reference through a self-relative pointer cell |
| req_xsel | input | 2 | Index selector, 0 = none, 1..3 = R5..R7 |
| req_byte | input | 1 | Byte-mode access |
| stk_regs | input | 128 | Eight 16-bit stack registers, register k in bits 16k+15:16k |
| ready | output | 1 | Unit idle, can accept a request |
| mem_rd_en | output | 1 | Code-memory read enable, data returns the next cycle |
| mem_rd_addr | output | 16 | Code-memory read address |
| mem_rd_data | input | 16 | Code-memory read data |
| done | output | 1 | Result valid strobe |
| out_word_addr | output | 16 | Final word address |
| out_byte_lo | output | 1 | Byte select, 1 = low byte |
| out_is_byte | output | 1 | Result is a byte access |

## Verification
The bench aims at sums that wrap past 0xFFFF and at pointer cells with negative contents that land below the program counter. A design that ignores the sign or the carry would return an address that is wrong by 2^16 or lands in the wrong place. It builds byte cases where the program counter and the pointer cell lie in different halves. A design that always takes the half from the program counter, or from the sum, would flip bit 15 of the word address. Extra request strobes are driven while an indirect access is still running. A design that accepted them would produce a second done or a wrong result. Latency and read counts are checked per request, which catches a missing or doubled fetch cycle.

// File: rtl/cseg_pkg.sv
package cseg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CALC,
        ST_DONE
    } cseg_state_e;

    localparam int unsigned IDX_WINDOW = 3;
endpackage

// File: rtl/cseg_idx_sel.sv
module cseg_idx_sel
    import cseg_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic [NREG*W-1:0] regs,
    input  logic [1:0]        xsel,
    output logic [W-1:0]      idx_val
);
    localparam int WBASE = NREG - IDX_WINDOW;

    logic [W-1:0] win [IDX_WINDOW];

    for (genvar g = 0; g < IDX_WINDOW; g++) begin : g_win
        assign win[g] = regs[(WBASE + g)*W +: W];
    end

    // registers below the index window are not used here
    logic unused_low;
    assign unused_low = ^regs[WBASE*W-1:0];

    always_comb begin
        unique case (xsel)
            2'd1:    idx_val = win[0];
            2'd2:    idx_val = win[1];
            2'd3:    idx_val = win[2];
            default: idx_val = '0;
        endcase
    end
endmodule

// File: rtl/cseg_final_fmt.sv
module cseg_final_fmt #(
    parameter int W = 16
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] idx,
    input  logic         is_byte,
    input  logic         half,
    output logic [W-1:0] word_addr,
    output logic         byte_lo
);
    logic [W-1:0] sum;

    always_comb begin
        sum = base + idx;
        if (is_byte) begin
            word_addr = {half, sum[W-1:1]};
            byte_lo   = sum[0];
        end else begin
            word_addr = sum;
            byte_lo   = 1'b0;
        end
    end
endmodule

// File: rtl/cseg_addr_gen.sv
module cseg_addr_gen
    import cseg_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NREG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AW-1:0]      req_pc,
    input  logic [AW-1:0]      req_disp,
    input  logic               req_indirect,
    input  logic [1:0]         req_xsel,
    input  logic               req_byte,
    input  logic [NREG*AW-1:0] stk_regs,
    output logic               ready,
    output logic               mem_rd_en,
    output logic [AW-1:0]      mem_rd_addr,
    input  logic [AW-1:0]      mem_rd_data,
    output logic               done,
    output logic [AW-1:0]      out_word_addr,
    output logic               out_byte_lo,
    output logic               out_is_byte
);
    cseg_state_e state_q, state_d;

    logic [AW-1:0] ref_q, idx_q, idx_val;
    logic          pc_hi_q, ind_q, byte_q;
    logic [AW-1:0] base, fmt_addr;
    logic          half, fmt_blo;
    logic [AW-1:0] res_addr_q;
    logic          res_blo_q, res_isb_q;
    logic          accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    cseg_idx_sel #(.W(AW), .NREG(NREG)) u_idx (
        .regs    (stk_regs),
        .xsel    (req_xsel),
        .idx_val (idx_val)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = req_indirect ? ST_FETCH : ST_CALC;
            ST_FETCH: state_d = ST_CALC;
            ST_CALC:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // base and half selection; cell contents are a self-relative offset
    always_comb begin
        base = ind_q ? (ref_q + mem_rd_data) : ref_q;
        half = ind_q ? ref_q[AW-1] : pc_hi_q;
    end

    cseg_final_fmt #(.W(AW)) u_fmt (
        .base      (base),
        .idx       (idx_q),
        .is_byte   (byte_q),
        .half      (half),
        .word_addr (fmt_addr),
        .byte_lo   (fmt_blo)
    );

    // request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q      <= '0;
            idx_q      <= '0;
            pc_hi_q    <= 1'b0;
            ind_q      <= 1'b0;
            byte_q     <= 1'b0;
            res_addr_q <= '0;
            res_blo_q  <= 1'b0;
            res_isb_q  <= 1'b0;
        end else begin
            if (accept) begin
                ref_q   <= req_pc + req_disp;
                idx_q   <= idx_val;
                pc_hi_q <= req_pc[AW-1];
                ind_q   <= req_indirect;
                byte_q  <= req_byte;
            end
            if (state_q == ST_CALC) begin
                res_addr_q <= fmt_addr;
                res_blo_q  <= fmt_blo;
                res_isb_q  <= byte_q;
            end
        end
    end

    // outputs
    always_comb begin
        ready         = (state_q == ST_IDLE);
        mem_rd_en     = (state_q == ST_FETCH);
        mem_rd_addr   = ref_q;
        done          = (state_q == ST_DONE);
        out_word_addr = res_addr_q;
        out_byte_lo   = res_blo_q;
        out_is_byte   = res_isb_q;
    end
endmodule

// File: rtl/cseg_addr_gen_chk.sv
module cseg_addr_gen_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_pc,
    input logic [AW-1:0] req_disp,
    input logic          req_indirect,
    input logic [1:0]    req_xsel,
    input logic          req_byte,
    input logic          ready,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          done,
    input logic [AW-1:0] out_word_addr,
    input logic          out_is_byte
);
    AST_IND_READS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_indirect) |=>
            (mem_rd_en && mem_rd_addr == AW'($past(req_pc) + $past(req_disp)))); // R2

    AST_DIRECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && !req_indirect) |=> !mem_rd_en); // R8

    AST_DIRECT_PLAIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && !req_indirect && !req_byte && req_xsel == 2'd0) |=> ##1
            (done && out_word_addr == AW'($past(req_pc, 2) + $past(req_disp, 2)))); // R1

    AST_DIRECT_BYTE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && !req_indirect && req_byte) |=> ##1
            (done && out_is_byte && out_word_addr[AW-1] == $past(req_pc[AW-1], 2))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready); // R10
endmodule

bind cseg_addr_gen cseg_addr_gen_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_pc        (req_pc),
    .req_disp      (req_disp),
    .req_indirect  (req_indirect),
    .req_xsel      (req_xsel),
    .req_byte      (req_byte),
    .ready         (ready),
    .mem_rd_en     (mem_rd_en),
    .mem_rd_addr   (mem_rd_addr),
    .done          (done),
    .out_word_addr (out_word_addr),
    .out_is_byte   (out_is_byte)
);

// File: tb/sim_cseg_addr_gen.sv
`timescale 1ns/1ps
module sim_cseg_addr_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [15:0]  req_pc = '0;
    logic [15:0]  req_disp = '0;
    logic         req_indirect = 1'b0;
    logic [1:0]   req_xsel = '0;
    logic         req_byte = 1'b0;
    logic [127:0] stk_regs = '0;
    logic         ready, mem_rd_en, done, out_byte_lo, out_is_byte;
    logic [15:0]  mem_rd_addr, out_word_addr;
    logic [15:0]  mem_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] addr;
        logic        blo;
        logic        isb;
        logic        ind;
        int          acc;
        string       tag;
    } item_t;

    item_t q[$];

    always #5 clk = ~clk;

    cseg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_disp(req_disp), .req_indirect(req_indirect), .req_xsel(req_xsel),
        .req_byte(req_byte), .stk_regs(stk_regs), .ready(ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .done(done), .out_word_addr(out_word_addr), .out_byte_lo(out_byte_lo),
        .out_is_byte(out_is_byte)
    );

    // code memory model: a few planted pointer cells, the rest hashed
    function automatic logic [15:0] cell_val(input logic [15:0] a);
        case (a)
            16'd3737: return 16'hFED0;   // -304
            16'h8010: return 16'hFFF0;   // -16
            16'h7FF8: return 16'h0010;
            default:  return a ^ 16'h5A5A;
        endcase
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= cell_val(mem_rd_addr);
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model from the requirements
    function automatic item_t model(input logic [15:0] pc, disp, input logic ind,
                                    input logic [1:0] xs, input logic isb);
        item_t it;
        logic [15:0] rf, base, idx, s;
        logic half;
        rf   = pc + disp;
        base = ind ? rf + cell_val(rf) : rf;
        idx  = (xs == 2'd0) ? 16'h0 : stk_regs[(4 + int'(xs))*16 +: 16];
        s    = base + idx;
        half = ind ? rf[15] : pc[15];
        it.addr = isb ? {half, s[15:1]} : s;
        it.blo  = isb ? s[0] : 1'b0;
        it.isb  = isb;
        it.ind  = ind;
        it.acc  = 0;
        it.tag  = "";
        return it;
    endfunction

    task automatic send(input logic [15:0] pc, disp, input logic ind,
                        input logic [1:0] xs, input logic isb, input string tag);
        item_t it;
        while (!ready) @(negedge clk);
        req_pc = pc; req_disp = disp; req_indirect = ind; req_xsel = xs; req_byte = isb;
        req_valid = 1'b1;
        it = model(pc, disp, ind, xs, isb);
        it.tag = tag;
        @(posedge clk);
        @(negedge clk);
        it.acc = cyc;
        q.push_back(it);
        req_valid = 1'b0;
    endtask

    // monitor / scoreboard
    int  rd_cnt = 0;
    bit  prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en) rd_cnt++;
            if (done) begin
                chk(!prev_done, "R9 done single pulse", 32'(prev_done), 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R10 done with no accepted request", 1, 0);
                end else begin
                    item_t e;
                    e = q.pop_front();
                    chk(out_word_addr == e.addr, e.tag, 32'(out_word_addr), 32'(e.addr));
                    chk(out_byte_lo == e.blo && out_is_byte == e.isb, "R5 byte select/flag",
                        {30'd0, out_is_byte, out_byte_lo}, {30'd0, e.isb, e.blo});
                    chk(cyc - e.acc == (e.ind ? 2 : 1), "R8 latency",
                        32'(cyc - e.acc), e.ind ? 2 : 1);
                    chk(rd_cnt == (e.ind ? 1 : 0), "R8/R2 memory read count",
                        32'(rd_cnt), e.ind ? 1 : 0);
                end
                rd_cnt = 0;
            end
            prev_done = done;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        stk_regs[5*16 +: 16] = 16'd7;
        stk_regs[6*16 +: 16] = 16'd6;
        stk_regs[7*16 +: 16] = 16'h0101;
        stk_regs[4*16 +: 16] = 16'h4444;
        stk_regs[0 +: 16]    = 16'h1111;
        repeat (2) @(negedge clk);
        chk(ready == 1'b1 && done == 1'b0 && mem_rd_en == 1'b0, "R11 reset state",
            {29'd0, ready, done, mem_rd_en}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1 && done == 1'b0 && mem_rd_en == 1'b0, "R11 after reset",
            {29'd0, ready, done, mem_rd_en}, 32'b100);

        send(16'd3729, 16'd8, 1'b0, 2'd0, 1'b0, "R1 R4 direct unindexed");
        send(16'd3729, 16'd8, 1'b1, 2'd2, 1'b0, "R2 R3 indirect negative cell, R6 index");
        send(16'd3729, 16'd8, 1'b1, 2'd0, 1'b0, "R2 R4 indirect unindexed");
        send(16'h1000, 16'h0010, 1'b0, 2'd1, 1'b0, "R3 R5 register index");
        send(16'h1000, 16'h0010, 1'b0, 2'd3, 1'b0, "R3 R7 register index");
        send(16'hFFF0, 16'h0020, 1'b0, 2'd0, 1'b0, "R1 wrap");
        send(16'h9000, 16'h0004, 1'b0, 2'd1, 1'b1, "R5 R6 direct byte high half");
        send(16'h1000, 16'h8000, 1'b0, 2'd2, 1'b1, "R6 direct byte low half from pc");
        send(16'h7FF0, 16'h0008, 1'b1, 2'd1, 1'b1, "R7 indirect byte cell low half");
        send(16'h0FF0, 16'h7020, 1'b1, 2'd2, 1'b1, "R7 indirect byte cell high half");

        // R10: strobes while busy must be ignored
        send(16'd3729, 16'd8, 1'b1, 2'd2, 1'b0, "R10 indirect with busy strobes");
        req_pc = 16'h2222; req_disp = 16'h0001; req_indirect = 1'b0; req_byte = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R10 idle after ignored strobes", 32'(ready), 1);
        chk(q.size() == 0, "R10 no pending result", 32'(q.size()), 0);

        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            r = $urandom;
            send(r[15:0], $urandom, r[16], r[18:17], r[19], "R1 R2 R3 R5 random mix");
        end

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule